// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sequences trap entry for a simple 64-bit RISC core. Each cycle it looks at a synchronous exception request (a cause code with sub-code, the faulting PC and the fetched instruction word), at the instruction and data bus error flags, and at the hardware interrupt lines. It decides whether a trap is taken and which kind it is: an ordinary exception, a hardware interrupt, a TLB-refill entry or a debug entry. It then updates its mode, saved-state, status and bad-address registers and issues a one-cycle redirect with the new PC.

Three entry paths keep separate saved state. The normal path covers exceptions and interrupts. The refill path saves into its own registers and jumps to its own base. The debug path saves into a debug return register and jumps to a fixed offset from the entry base. Exceptions and interrupts are spaced by a programmable stride. The interrupt vector is the highest-numbered line that is both pending and enabled. Software reaches every register through a small CSR port with a combinational read and a write that takes effect at the clock edge.

CSR map, with the field bit positions:
- 0 MODE: [1:0] privilege level, [2] interrupt enable, [3] direct-address, [4] paging.
- 1 SAVED: [1:0] previous level, [2] previous enable.
- 2 STATUS: read only; [NIRQ-1:0] live line levels, [21:16] major code, [30:22] sub-code.
- 3 RET: return PC.
- 4 BADADDR.
- 5 BADINST: [31:0].
- 6 VBASE: entry base.
- 7 ICFG: [NIRQ-1:0] line enables, [18:16] spacing field.
- 8 RSAVED: [1:0] level, [2] enable.
- 9 RRET: refill return.
- 10 RBASE: refill entry.
- 11 DCTL: [0] debug-state, [1] breakpoint cause, [2] debug-interrupt, [8:3] debug code.
- 12 DRET: debug return.

Unmapped addresses read zero.

Cause codes:
- 0: interrupt entry.
- 1 to 7: load, store and fetch page-invalid (fetch is 3), page-modified, not-readable, not-executable and page-privilege.
- 8: address error, with sub-code 0 for fetch and 1 for data.
- 9: bound check.
- 10 to 17: syscall, break, illegal instruction, instruction privilege, FP disabled, FP exception, 128-bit vector disabled and 256-bit vector disabled.
- 63: debug breakpoint.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A hardware interrupt is taken only when MODE[2] is 1, DCTL[0] is 0 and the line levels ANDed with ICFG[NIRQ-1:0] are nonzero. Otherwise, when no synchronous request is present, no redirect is issued.
- R2: The interrupt vector is the highest-numbered set bit of the line levels ANDed with the enables. The interrupt redirect PC is VBASE + (INT_BASE + vector) × spacing.
- R3: The spacing is 0 when ICFG[18:16] is 0. Otherwise it is 4 << ICFG[18:16] bytes.
- R4: A non-refill exception with code 1 to 17 redirects to VBASE + code × spacing. It writes the code and sub-code into STATUS[21:16] and STATUS[30:22], copies the old level and enable into SAVED, and stores the PC in RET. An interrupt entry writes major and sub-code 0.
- R5: Every interrupt, exception or refill entry sets MODE[1:0] to 0 and MODE[2] to 0.
- R6: Code 63 sets DCTL[1], writes 0xC into DCTL[8:3], sets DCTL[0] and stores the PC in DRET. It redirects to VBASE + 0x480 and leaves MODE unchanged.
- R7: A code-0 request while DCTL[0] is 1 sets DCTL[2] and takes the debug path of R6 without touching DCTL[1] or DCTL[8:3].
- R8: An exception with the refill flag set saves the level and enable into RSAVED, sets MODE[3] to 1 and MODE[4] to 0, and stores PC >> 2 in RRET. It redirects to RBASE and leaves STATUS, SAVED and RET unchanged.
- R9: BADADDR is loaded with the PC only for codes 10 to 17.
- R10: BADINST captures the instruction word on every exception or refill entry except code 3 and code 8 with sub-code 0. Interrupt and debug entries never touch it.
- R11: An instruction bus error raises code 8 sub-code 0, and a data bus error raises code 8 sub-code 1. Precedence runs instruction bus error, then data bus error, then the request input, then a hardware interrupt.
- R12: The redirect strobe rises in the cycle after the accepted request and stays high for one cycle when the request lasts one cycle.
- R13: Codes 18 to 62 are ignored: no redirect and no register change.
- R14: After reset MODE reads 0x8 and every other register reads 0. A CSR write lands when no trap is taken in that cycle and is dropped when one is. STATUS ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 6 | Major cause code |
| exc_sub | input | 9 | Sub-code |
| tlb_refill | input | 1 | Request takes the refill path |
| ibus_err | input | 1 | Instruction fetch bus error |
| dbus_err | input | 1 | Data access bus error |
| epc | input | XLEN | PC of the trapping or interrupted instruction |
| inst | input | 32 | Fetched instruction word |
| irq_lines | input | NIRQ | Hardware interrupt line levels |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 4 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | XLEN | Redirect target PC |

## Verification
The bench builds the block with its defaults: 64-bit registers, 13 interrupt lines, an interrupt base code of 64 and a 3-bit spacing field. Every spacing from 0 through 512 bytes is therefore reachable, and vectors up to line 12 add offsets beyond the 12-bit range. Random trials sweep all spacings, cause codes, privilege and paging states and the refill flag. Directed cases cover debug re-entry, bus-error precedence, ignored codes and a CSR write colliding with a trap.

// File: rtl/trap_entry_ctrl.sv
`timescale 1ns/1ps
module trap_entry_ctrl #(
  parameter int XLEN     = 64,
  parameter int NIRQ     = 13,
  parameter int INT_BASE = 64,
  parameter int VSW      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [5:0]      exc_code,
  input  logic [8:0]      exc_sub,
  input  logic            tlb_refill,
  input  logic            ibus_err,
  input  logic            dbus_err,
  input  logic [XLEN-1:0] epc,
  input  logic [31:0]     inst,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic            csr_we,
  input  logic [3:0]      csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  localparam int VECW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [5:0] C_INT = 6'd0, C_PIF = 6'd3, C_ADE = 6'd8;
  localparam logic [5:0] C_SYS = 6'd10, C_LAST = 6'd17, C_DBP = 6'd63;
  localparam logic [5:0] DBG_CODE = 6'hC;
  localparam logic [XLEN-1:0] DBG_OFF = XLEN'(12'h480);
  localparam logic [3:0] A_MODE = 4'd0, A_SAVED = 4'd1, A_STAT = 4'd2, A_RET = 4'd3,
                         A_BADA = 4'd4, A_BADI = 4'd5, A_VBASE = 4'd6, A_ICFG = 4'd7,
                         A_RSAVED = 4'd8, A_RRET = 4'd9, A_RBASE = 4'd10, A_DCTL = 4'd11,
                         A_DRET = 4'd12;

  typedef enum logic [2:0] {K_NONE, K_INT, K_EXC, K_RFL, K_DBG} kind_t;

  logic [1:0]      plv_q, pplv_q, rpplv_q;
  logic            ie_q, da_q, pg_q, pie_q, rpie_q;
  logic [5:0]      maj_q, dcode_q;
  logic [8:0]      sub_q;
  logic [XLEN-1:0] ret_q, bada_q, vbase_q, rret_q, rbase_q, dret_q;
  logic [31:0]     badi_q;
  logic [NIRQ-1:0] lie_q;
  logic [VSW-1:0]  vs_q;
  logic            dst_q, dcl_q, dei_q;

  logic            sync_req, code_ok, hw_irq, set_bada, set_badi;
  logic [5:0]      code;
  logic [8:0]      sub;
  logic [NIRQ-1:0] act_irq;
  logic [VECW-1:0] vec;
  logic [XLEN-1:0] vec_code, vec_off, target;
  kind_t           kind;

  assign sync_req = ibus_err | dbus_err | exc_req;
  assign code     = (ibus_err | dbus_err) ? C_ADE : exc_code;
  assign sub      = ibus_err ? 9'd0 : (dbus_err ? 9'd1 : exc_sub);
  assign code_ok  = (code <= C_LAST) || (code == C_DBP);
  assign act_irq  = irq_lines & lie_q;
  assign hw_irq   = ie_q & ~dst_q & (|act_irq);

  always_comb begin
    kind = K_NONE;
    if (sync_req) begin
      if (!code_ok)             kind = K_NONE;
      else if (code == C_DBP)   kind = K_DBG;
      else if (code == C_INT)   kind = dst_q ? K_DBG : K_INT;
      else if (tlb_refill)      kind = K_RFL;
      else                      kind = K_EXC;
    end else if (hw_irq) begin
      kind = K_INT;
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NIRQ; i++)
      if (act_irq[i]) vec = VECW'(i);
  end

  assign vec_code = (kind == K_INT) ? XLEN'(INT_BASE) + XLEN'(vec) : XLEN'(code);
  assign vec_off  = (vs_q == '0) ? '0 : (vec_code << (vs_q + 2));

  always_comb begin
    case (kind)
      K_DBG:   target = vbase_q + DBG_OFF;
      K_RFL:   target = rbase_q;
      default: target = vbase_q + vec_off;
    endcase
  end

  assign set_bada = (kind == K_EXC || kind == K_RFL) && code >= C_SYS && code <= C_LAST;
  assign set_badi = (kind == K_EXC || kind == K_RFL) && code != C_PIF &&
                    !(code == C_ADE && sub == 9'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      plv_q  <= '0;  ie_q <= 1'b0; da_q <= 1'b1; pg_q <= 1'b0;
      pplv_q <= '0;  pie_q <= 1'b0;
      rpplv_q <= '0; rpie_q <= 1'b0;
      maj_q  <= '0;  sub_q <= '0;
      ret_q  <= '0;  bada_q <= '0; badi_q <= '0; vbase_q <= '0;
      lie_q  <= '0;  vs_q <= '0;
      rret_q <= '0;  rbase_q <= '0;
      dst_q  <= 1'b0; dcl_q <= 1'b0; dei_q <= 1'b0; dcode_q <= '0; dret_q <= '0;
    end else begin
      redirect_valid <= (kind != K_NONE);
      redirect_pc    <= target;
      if (kind == K_NONE && csr_we) begin
        case (csr_addr)
          A_MODE:   begin plv_q <= csr_wdata[1:0]; ie_q <= csr_wdata[2];
                          da_q <= csr_wdata[3]; pg_q <= csr_wdata[4]; end
          A_SAVED:  begin pplv_q <= csr_wdata[1:0]; pie_q <= csr_wdata[2]; end
          A_RET:    ret_q <= csr_wdata;
          A_BADA:   bada_q <= csr_wdata;
          A_BADI:   badi_q <= csr_wdata[31:0];
          A_VBASE:  vbase_q <= csr_wdata;
          A_ICFG:   begin lie_q <= csr_wdata[NIRQ-1:0]; vs_q <= csr_wdata[16 +: VSW]; end
          A_RSAVED: begin rpplv_q <= csr_wdata[1:0]; rpie_q <= csr_wdata[2]; end
          A_RRET:   rret_q <= csr_wdata;
          A_RBASE:  rbase_q <= csr_wdata;
          A_DCTL:   begin dst_q <= csr_wdata[0]; dcl_q <= csr_wdata[1];
                          dei_q <= csr_wdata[2]; dcode_q <= csr_wdata[8:3]; end
          A_DRET:   dret_q <= csr_wdata;
          default: ;
        endcase
      end
      if (set_bada) bada_q <= epc;
      if (set_badi) badi_q <= inst;
      case (kind)
        K_INT, K_EXC: begin
          pplv_q <= plv_q;
          pie_q  <= ie_q;
          maj_q  <= (kind == K_INT) ? C_INT : code;
          sub_q  <= (kind == K_INT) ? 9'd0 : sub;
          ret_q  <= epc;
          plv_q  <= '0;
          ie_q   <= 1'b0;
        end
        K_RFL: begin
          rpplv_q <= plv_q;
          rpie_q  <= ie_q;
          da_q    <= 1'b1;
          pg_q    <= 1'b0;
          rret_q  <= epc >> 2;
          plv_q   <= '0;
          ie_q    <= 1'b0;
        end
        K_DBG: begin
          if (code == C_DBP) begin
            dcl_q   <= 1'b1;
            dcode_q <= DBG_CODE;
          end else begin
            dei_q   <= 1'b1;
          end
          dret_q <= epc;
          dst_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_MODE:   csr_rdata = XLEN'({pg_q, da_q, ie_q, plv_q});
      A_SAVED:  csr_rdata = XLEN'({pie_q, pplv_q});
      A_STAT:   begin
                  csr_rdata[NIRQ-1:0] = irq_lines;
                  csr_rdata[21:16]    = maj_q;
                  csr_rdata[30:22]    = sub_q;
                end
      A_RET:    csr_rdata = ret_q;
      A_BADA:   csr_rdata = bada_q;
      A_BADI:   csr_rdata = XLEN'(badi_q);
      A_VBASE:  csr_rdata = vbase_q;
      A_ICFG:   begin
                  csr_rdata[NIRQ-1:0] = lie_q;
                  csr_rdata[16 +: VSW] = vs_q;
                end
      A_RSAVED: csr_rdata = XLEN'({rpie_q, rpplv_q});
      A_RRET:   csr_rdata = rret_q;
      A_RBASE:  csr_rdata = rbase_q;
      A_DCTL:   csr_rdata = XLEN'({dcode_q, dei_q, dcl_q, dst_q});
      A_DRET:   csr_rdata = dret_q;
      default:  csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_entry_chk.sv
`timescale 1ns/1ps
module trap_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic [5:0]      exc_code,
  input logic            ibus_err,
  input logic            dbus_err,
  input logic            tlb_refill,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [1:0]      plv_q,
  input logic            ie_q,
  input logic            da_q,
  input logic            pg_q,
  input logic            dst_q,
  input logic [XLEN-1:0] vbase_q,
  input logic [XLEN-1:0] rbase_q,
  input logic [2:0]      kind
);
  p_irq_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q && !exc_req && !ibus_err && !dbus_err) |=> !redirect_valid);

  p_entry_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 3'd1 || kind == 3'd2 || kind == 3'd3) |=> (plv_q == 2'd0 && !ie_q));

  p_dbg_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !ibus_err && !dbus_err && exc_code == 6'd63)
      |=> (redirect_valid && dst_q && redirect_pc == $past(vbase_q) + XLEN'(12'h480)));

  p_refill_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !ibus_err && !dbus_err && tlb_refill && exc_code inside {[6'd1:6'd17]})
      |=> (da_q && !pg_q && redirect_valid && redirect_pc == $past(rbase_q)));

  p_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !ibus_err && !dbus_err && exc_code inside {[6'd18:6'd62]}) |=> !redirect_valid);
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
  .ibus_err(ibus_err), .dbus_err(dbus_err), .tlb_refill(tlb_refill),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .plv_q(plv_q), .ie_q(ie_q), .da_q(da_q), .pg_q(pg_q), .dst_q(dst_q),
  .vbase_q(vbase_q), .rbase_q(rbase_q), .kind(kind)
);

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;
  localparam int XLEN = 64, NIRQ = 13, IB = 64;
  localparam logic [3:0] A_MODE = 0, A_SAVED = 1, A_STAT = 2, A_RET = 3, A_BADA = 4,
                         A_BADI = 5, A_VBASE = 6, A_ICFG = 7, A_RSAVED = 8, A_RRET = 9,
                         A_RBASE = 10, A_DCTL = 11, A_DRET = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_req = 0, tlb_refill = 0, ibus_err = 0, dbus_err = 0, csr_we = 0;
  logic [5:0] exc_code = 0;
  logic [8:0] exc_sub = 0;
  logic [XLEN-1:0] epc = 0, csr_wdata = 0, csr_rdata, redirect_pc;
  logic [31:0] inst = 0;
  logic [NIRQ-1:0] irq_lines = 0;
  logic [3:0] csr_addr = 0;
  logic redirect_valid;

  always #2.5 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ), .INT_BASE(IB), .VSW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code), .exc_sub(exc_sub),
    .tlb_refill(tlb_refill), .ibus_err(ibus_err), .dbus_err(dbus_err), .epc(epc),
    .inst(inst), .irq_lines(irq_lines), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] v);
    csr_addr = a;
    #0.2;
    v = csr_rdata;
  endtask

  task automatic trap(input logic r, input logic [5:0] c, input logic [8:0] s, input logic rf,
                      input logic ib, input logic db, input logic [63:0] pc, input logic [31:0] ins);
    exc_req = r; exc_code = c; exc_sub = s; tlb_refill = rf;
    ibus_err = ib; dbus_err = db; epc = pc; inst = ins;
    @(negedge clk);
    exc_req = 0; tlb_refill = 0; ibus_err = 0; dbus_err = 0;
  endtask

  function automatic logic [63:0] f_off(input logic [63:0] k, input int vs);
    return (vs == 0) ? 64'd0 : (k << (vs + 2));
  endfunction

  function automatic int f_top(input logic [NIRQ-1:0] m);
    int t = 0;
    for (int i = 0; i < NIRQ; i++) if (m[i]) t = i;
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, stat0;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R14 reset state and write rules
    rd(A_MODE, v);  chk("R14 reset MODE", v, 64'h8);
    rd(A_DCTL, v);  chk("R14 reset DCTL", v, 0);
    rd(A_VBASE, v); chk("R14 reset VBASE", v, 0);
    chk("R12 idle strobe", redirect_valid, 0);
    @(negedge clk);
    wr(A_VBASE, 64'h1000_0000); rd(A_VBASE, v); chk("R14 write VBASE", v, 64'h1000_0000);
    @(negedge clk);
    wr(A_STAT, '1); rd(A_STAT, v); chk("R14 STATUS read-only", v, 0);
    @(negedge clk);

    // R1 gating
    wr(A_ICFG, 64'h1fff); wr(A_MODE, 64'h2);
    irq_lines = 13'h0050;
    @(negedge clk); chk("R1 ie=0 no redirect", redirect_valid, 0);
    wr(A_ICFG, 64'h20000);
    wr(A_MODE, 64'h6);
    @(negedge clk); chk("R1 no enables no redirect", redirect_valid, 0);
    epc = 64'hA000;
    wr(A_ICFG, 64'h21fff);
    @(negedge clk);
    chk("R1 irq taken", redirect_valid, 1);
    chk("R2 irq vector target", redirect_pc, 64'h1000_0000 + ((64 + 6) << 4));
    irq_lines = 0;
    rd(A_MODE, v);  chk("R5 irq clears plv/ie", v, 64'h0);
    rd(A_SAVED, v); chk("R4 irq saved mode", v, 64'h6);
    rd(A_STAT, v);  chk("R4 irq status code 0", v[30:16], 0);
    rd(A_RET, v);   chk("R4 irq RET", v, 64'hA000);
    @(negedge clk); chk("R12 strobe one cycle", redirect_valid, 0);

    // R3 spacing 0
    wr(A_ICFG, 64'h1000);
    irq_lines = 13'h1fff;
    wr(A_MODE, 64'h4);
    @(negedge clk);
    chk("R3 vs=0 strobe", redirect_valid, 1);
    chk("R3 vs=0 target is base", redirect_pc, 64'h1000_0000);
    irq_lines = 0;
    @(negedge clk);

    // R6 debug breakpoint
    wr(A_MODE, 64'h6); wr(A_BADI, 64'h1234);
    trap(1, 6'd63, 0, 0, 0, 0, 64'hB000, 32'hFFFF_0000);
    chk("R6 dbg strobe", redirect_valid, 1);
    chk("R6 dbg target", redirect_pc, 64'h1000_0480);
    rd(A_DCTL, v); chk("R6 DCTL", v, 64'h63);
    rd(A_DRET, v); chk("R6 DRET", v, 64'hB000);
    rd(A_MODE, v); chk("R6 MODE unchanged", v, 64'h6);
    rd(A_BADI, v); chk("R10 dbg BADI unchanged", v, 64'h1234);
    @(negedge clk);

    // R1 / R7 while in debug state
    wr(A_ICFG, 64'h10001); irq_lines = 1;
    @(negedge clk); chk("R1 debug blocks irq", redirect_valid, 0);
    @(negedge clk); chk("R1 debug blocks irq 2", redirect_valid, 0);
    trap(1, 6'd0, 0, 0, 0, 0, 64'hC000, 0);
    chk("R7 dbg-int target", redirect_pc, 64'h1000_0480);
    chk("R7 dbg-int strobe", redirect_valid, 1);
    irq_lines = 0;
    rd(A_DCTL, v); chk("R7 DCTL dei", v, 64'h67);
    rd(A_DRET, v); chk("R7 DRET", v, 64'hC000);
    @(negedge clk);
    wr(A_DCTL, 0);

    // R8 refill
    wr(A_RBASE, 64'h8000_0000); wr(A_MODE, 64'h16);
    trap(1, 6'd1, 9'd0, 1, 0, 0, 64'h1234_5678, 32'h0);
    chk("R8 refill target", redirect_pc, 64'h8000_0000);
    rd(A_MODE, v);   chk("R8 refill MODE", v, 64'h8);
    rd(A_RSAVED, v); chk("R8 refill RSAVED", v, 64'h6);
    rd(A_RRET, v);   chk("R8 refill RRET", v, 64'h48D_159E);
    @(negedge clk);

    // R11 bus errors and precedence
    wr(A_ICFG, 64'h10000); wr(A_BADI, 64'h55);
    trap(1, 6'd10, 9'd7, 0, 1, 1, 64'hD000, 32'h77);
    chk("R11 ibus target", redirect_pc, 64'h1000_0000 + 64'h40);
    rd(A_STAT, v); chk("R11 ibus code", v[30:16], 64'h8);
    rd(A_BADI, v); chk("R10 fetch ADE BADI kept", v, 64'h55);
    @(negedge clk);
    trap(0, 6'd0, 9'd0, 0, 0, 1, 64'hD100, 32'h88);
    rd(A_STAT, v); chk("R11 dbus code", v[30:16], 64'h48);
    rd(A_BADI, v); chk("R10 data ADE BADI", v, 64'h88);
    @(negedge clk);
    wr(A_ICFG, 64'h10001); wr(A_MODE, 64'h4);
    irq_lines = 1;
    trap(1, 6'd10, 9'd0, 0, 0, 0, 64'hD200, 0);
    irq_lines = 0;
    chk("R11 request beats irq target", redirect_pc, 64'h1000_0000 + 64'h50);
    rd(A_STAT, v); chk("R11 request beats irq code", v[21:16], 64'd10);
    @(negedge clk);

    // R13 ignored code
    wr(A_RET, 64'h9999); wr(A_MODE, 64'h6);
    trap(1, 6'd40, 9'd0, 0, 0, 0, 64'hE000, 0);
    chk("R13 no redirect", redirect_valid, 0);
    rd(A_RET, v);  chk("R13 RET unchanged", v, 64'h9999);
    rd(A_MODE, v); chk("R13 MODE unchanged", v, 64'h6);
    @(negedge clk);

    // R14 write dropped on trap
    csr_we = 1; csr_addr = A_VBASE; csr_wdata = 64'h2222_0000;
    trap(1, 6'd11, 9'd0, 0, 0, 0, 64'hF000, 0);
    csr_we = 0;
    rd(A_VBASE, v); chk("R14 write dropped on trap", v, 64'h1000_0000);
    @(negedge clk);

    // Random exceptions: R4 R5 R8 R9 R10 R12
    for (int it = 0; it < 60; it++) begin
      logic [63:0] base, rb, pc, m, exp;
      logic [5:0] c; logic [8:0] s; logic [31:0] ins; logic rf; int vs;
      c = 6'($urandom_range(1, 17)); s = 9'($urandom); vs = $urandom_range(0, 7);
      rf = ($urandom_range(0, 3) == 0);
      base = {$urandom, $urandom}; rb = {$urandom, $urandom}; pc = {$urandom, $urandom};
      ins = $urandom; m = 64'($urandom_range(0, 31));
      wr(A_VBASE, base); wr(A_RBASE, rb); wr(A_ICFG, 64'(vs) << 16);
      wr(A_MODE, m); wr(A_SAVED, 0); wr(A_RET, ~pc); wr(A_BADA, 64'hDEAD); wr(A_BADI, 64'hBEEF);
      rd(A_STAT, stat0);
      @(negedge clk);
      trap(1, c, s, rf, 0, 0, pc, ins);
      chk("R12 random strobe", redirect_valid, 1);
      exp = rf ? rb : base + f_off(64'(c), vs);
      chk(rf ? "R8 random target" : "R4 random target", redirect_pc, exp);
      @(negedge clk);
      chk("R12 random strobe drop", redirect_valid, 0);
      rd(A_MODE, v);
      chk("R5 random MODE", v, rf ? 64'h8 : {59'd0, m[4:3], 3'd0});
      if (rf) begin
        rd(A_RSAVED, v); chk("R8 random RSAVED", v, {61'd0, m[2:0]});
        rd(A_RRET, v);   chk("R8 random RRET", v, pc >> 2);
        rd(A_RET, v);    chk("R8 random RET kept", v, ~pc);
        rd(A_STAT, v);   chk("R8 random STATUS kept", v, stat0);
      end else begin
        rd(A_SAVED, v);  chk("R4 random SAVED", v, {61'd0, m[2:0]});
        rd(A_RET, v);    chk("R4 random RET", v, pc);
        rd(A_STAT, v);   chk("R4 random STATUS", v[30:16], {49'd0, s, c});
      end
      rd(A_BADA, v); chk("R9 random BADADDR", v, (c >= 10) ? pc : 64'hDEAD);
      rd(A_BADI, v);
      chk("R10 random BADINST", v, (c != 3 && !(c == 8 && s == 0)) ? {32'd0, ins} : 64'hBEEF);
      @(negedge clk);
    end

    // Random interrupts: R2 R3 R5
    for (int it = 0; it < 20; it++) begin
      logic [NIRQ-1:0] en, ln; logic [63:0] base; int vs;
      en = NIRQ'($urandom) | NIRQ'(1 << $urandom_range(0, NIRQ - 1));
      ln = NIRQ'($urandom) | (en & NIRQ'(1 << $urandom_range(0, NIRQ - 1)));
      if ((en & ln) == 0) ln = en;
      vs = $urandom_range(0, 7); base = {$urandom, $urandom};
      wr(A_VBASE, base); wr(A_ICFG, (64'(vs) << 16) | 64'(en));
      irq_lines = ln;
      wr(A_MODE, 64'h7);
      @(negedge clk);
      chk("R2 random irq strobe", redirect_valid, 1);
      chk("R2 random irq target", redirect_pc, base + f_off(64'(IB + f_top(en & ln)), vs));
      irq_lines = 0;
      rd(A_MODE, v); chk("R5 random irq MODE", v, 0);
      @(negedge clk);
      chk("R12 random irq strobe drop", redirect_valid, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule